// File: doc/BRIEF.md
# Shared-Region Pointer Guard

This block keeps a small on-chip table of temporary grants. A grant lets one principal reach a byte range `[low, high)` that another principal owns, with a read right, a write right or both. When a grant is installed for the address held in a general register, that register is tagged with the slot number of the grant and a pointer-valid bit. The tag travels with the value when the register is copied, and it is dropped when a null value is written to the register.

Every memory access names the register that supplies its address. If that register carries a valid tag, the access is checked against the tagged slot in a single cycle. The check compares the address range, the running principal's ID and the access type. Any mismatch raises a fault. An access through an untagged register is never checked and never faults.

When every slot is in use, a new grant replaces a slot picked by a free-running LFSR. The grant response reports the chosen slot and whether a live grant was overwritten, so that trusted software can save the overwritten grant elsewhere. All command inputs are accepted on every cycle without back-pressure: there is no ready signal, and a valid pulse is consumed at the clock edge where it is seen.

Top module: `spb_guard`

## Requirements
- R1: After reset, all slots are empty, no register carries a tag, and `grant_ack`, `grant_evict`, `acc_done`, `acc_checked` and `acc_fault` are low.
- R2: A grant goes into the lowest-numbered empty slot. One cycle later, `grant_ack` pulses, `grant_slot` gives that slot and `grant_evict` is 0.
- R3: When no slot is empty, a grant overwrites the slot named by the LFSR. One cycle later, `grant_evict` is 1, and the new grant is in force through the tagged register.
- R4: A grant tags register `grant_reg` with the slot and sets its pointer-valid bit. Accesses on the next cycle already see the tag.
- R5: A write with `rw_copy`=1 copies the tag (slot and valid bit) of `rw_src` into `rw_dst`.
- R6: A write with `rw_copy`=0 writes a null value and clears the pointer-valid bit of `rw_dst`.
- R7: An access through a tagged register passes when `low <= addr < high`, the access PID equals the grant PID, and the access type is permitted (`acc_write`=1 needs the write right, 0 needs the read right). The result appears one cycle after `acc_valid`, with `acc_done`=1, `acc_checked`=1 and `acc_fault`=0.
- R8: The range check is inclusive at `low` and exclusive at `high`. An address equal to `high`, or equal to `low-1`, faults.
- R9: A PID mismatch faults. A write through a read-only grant also faults.
- R10: An access through an untagged register gives `acc_checked`=0 and `acc_fault`=0, whatever the address or PID.
- R11: A revoke empties the named slot. A later access through a register still tagged with that slot faults, and the slot becomes the first choice for the next grant.
- R12: When a grant and a register write target the same register in the same cycle, the grant's tag wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_valid | input | 1 | Install a grant this cycle |
| grant_reg | input | REG_W | Register that is tagged with the new grant |
| grant_lo | input | ADDR_W | Lowest address of the range (inclusive) |
| grant_hi | input | ADDR_W | End of the range (exclusive) |
| grant_pid | input | PID_W | Principal that receives the grant |
| grant_rd | input | 1 | Read right |
| grant_wr | input | 1 | Write right |
| grant_ack | output | 1 | Pulses one cycle after a grant |
| grant_slot | output | IDX_W | Slot used by the last grant |
| grant_evict | output | 1 | The last grant overwrote a live slot |
| revoke_valid | input | 1 | Empty a slot this cycle |
| revoke_slot | input | IDX_W | Slot to empty |
| rw_valid | input | 1 | A register write happens this cycle |
| rw_copy | input | 1 | 1: register copy, 0: null write |
| rw_dst | input | REG_W | Destination register |
| rw_src | input | REG_W | Source register for a copy |
| acc_valid | input | 1 | Memory access to check |
| acc_reg | input | REG_W | Register that supplies the address |
| acc_addr | input | ADDR_W | Access address |
| acc_pid | input | PID_W | Running principal ID |
| acc_write | input | 1 | 1: store, 0: load |
| acc_done | output | 1 | Check result valid (one cycle after `acc_valid`) |
| acc_checked | output | 1 | The access went through a tagged register |
| acc_fault | output | 1 | Tagged access failed the check |

## Verification
The range check is driven at the inclusive low edge, just inside the exclusive high edge, at the high edge itself and one below the low edge. Each edge probe separates an off-by-one error from a correct compare. Further accesses keep the address in range and vary one thing at a time: a wrong PID, a store through a read-only grant, or a slot that has been revoked. A failing access can then only be explained by the field that was changed. Untagged, copied and nulled registers are probed with addresses that a live grant would reject, so a tag that was wrongly kept or wrongly dropped shows up as a changed `acc_checked` or `acc_fault`. The table is filled slot by slot and then overfilled, which shows the lowest-empty-first order and the switch to eviction. A grant and a null write to the same register in one cycle show which update has priority.

// File: rtl/spb_pkg.sv
package spb_pkg;

  typedef enum logic {
    RW_NULL = 1'b0,
    RW_COPY = 1'b1
  } rw_op_e;

  // x^8 + x^6 + x^5 + x^4 + 1
  function automatic logic [7:0] lfsr8_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [15:0] lfsr16_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/spb_victim_sel.sv
module spb_victim_sel #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld,
  output logic [IDX_W-1:0]   slot,
  output logic               evict
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rnd_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  generate
    if (IDX_W <= 8) begin : g_lfsr8
      logic [7:0] lfsr_q;
      always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= 8'hB5;
        else        lfsr_q <= spb_pkg::lfsr8_next(lfsr_q);
      end
      assign rnd_idx = lfsr_q[IDX_W-1:0];
    end else begin : g_lfsr16
      logic [15:0] lfsr_q;
      always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= 16'hACE1;
        else        lfsr_q <= spb_pkg::lfsr16_next(lfsr_q);
      end
      assign rnd_idx = lfsr_q[IDX_W-1:0];
    end
  endgenerate

  assign slot  = free_found ? free_idx : rnd_idx;
  assign evict = ~free_found;
endmodule

// File: rtl/spb_entry_table.sv
module spb_entry_table #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  parameter int PID_W   = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_lo,
  input  logic [ADDR_W-1:0] ins_hi,
  input  logic [PID_W-1:0]  ins_pid,
  input  logic              ins_rd,
  input  logic              ins_wr,
  output logic [IDX_W-1:0]  ins_slot,
  output logic              ins_evict,
  input  logic              rev_en,
  input  logic [IDX_W-1:0]  rev_idx,
  input  logic [IDX_W-1:0]  look_idx,
  output logic              look_vld,
  output logic [ADDR_W-1:0] look_lo,
  output logic [ADDR_W-1:0] look_hi,
  output logic [PID_W-1:0]  look_pid,
  output logic              look_rd,
  output logic              look_wr
);
  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  lo_q  [ENTRIES];
  logic [ADDR_W-1:0]  hi_q  [ENTRIES];
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [ENTRIES-1:0] rd_q;
  logic [ENTRIES-1:0] wr_q;

  spb_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (vld_q),
    .slot  (ins_slot),
    .evict (ins_evict)
  );

  // A revoke and a grant on the same slot: the grant is applied last.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        lo_q[e]  <= '0;
        hi_q[e]  <= '0;
        pid_q[e] <= '0;
      end
    end else begin
      if (rev_en) vld_q[rev_idx] <= 1'b0;
      if (ins_en) begin
        vld_q[ins_slot] <= 1'b1;
        lo_q[ins_slot]  <= ins_lo;
        hi_q[ins_slot]  <= ins_hi;
        pid_q[ins_slot] <= ins_pid;
        rd_q[ins_slot]  <= ins_rd;
        wr_q[ins_slot]  <= ins_wr;
      end
    end
  end

  assign look_vld = vld_q[look_idx];
  assign look_lo  = lo_q[look_idx];
  assign look_hi  = hi_q[look_idx];
  assign look_pid = pid_q[look_idx];
  assign look_rd  = rd_q[look_idx];
  assign look_wr  = wr_q[look_idx];

  // R2: an installed slot is live on the next cycle
  p_install_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> vld_q[$past(ins_slot)]);

  // R11: a revoke not overridden by a grant empties the slot
  p_revoke_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_en && !(ins_en && ins_slot == rev_idx)) |=> !vld_q[$past(rev_idx)]);
endmodule

// File: rtl/spb_reg_tags.sv
module spb_reg_tags #(
  parameter int REGS  = 16,
  parameter int IDX_W = 6,
  parameter int REG_W = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  spb_pkg::rw_op_e  wr_op,
  input  logic [REG_W-1:0] wr_dst,
  input  logic [REG_W-1:0] wr_src,
  input  logic             tag_en,
  input  logic [REG_W-1:0] tag_reg,
  input  logic [IDX_W-1:0] tag_idx,
  input  logic [REG_W-1:0] rd_reg,
  output logic             rd_v,
  output logic [IDX_W-1:0] rd_idx
);
  logic [REGS-1:0]  v_q;
  logic [IDX_W-1:0] idx_q [REGS];

  // The register write is applied first, then the grant tag, so the tag wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int r = 0; r < REGS; r++) idx_q[r] <= '0;
    end else begin
      if (wr_en) begin
        if (wr_op == spb_pkg::RW_COPY) begin
          v_q[wr_dst]   <= v_q[wr_src];
          idx_q[wr_dst] <= idx_q[wr_src];
        end else begin
          v_q[wr_dst]   <= 1'b0;
        end
      end
      if (tag_en) begin
        v_q[tag_reg]   <= 1'b1;
        idx_q[tag_reg] <= tag_idx;
      end
    end
  end

  assign rd_v   = v_q[rd_reg];
  assign rd_idx = idx_q[rd_reg];

  // R6: a null write drops the tag
  p_null_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == spb_pkg::RW_NULL && !(tag_en && tag_reg == wr_dst))
      |=> !v_q[$past(wr_dst)]);

  // R5: a copy carries the source valid bit
  p_copy_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == spb_pkg::RW_COPY && !(tag_en && tag_reg == wr_dst))
      |=> v_q[$past(wr_dst)] == $past(v_q[wr_src]));

  // R12: a grant tag survives a same-cycle write to its register
  p_grant_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tag_en |=> v_q[$past(tag_reg)]);
endmodule

// File: rtl/spb_guard.sv
module spb_guard #(
  parameter int ENTRIES = 64,
  parameter int REGS    = 16,
  parameter int ADDR_W  = 32,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int REG_W  = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  input  logic [REG_W-1:0]  grant_reg,
  input  logic [ADDR_W-1:0] grant_lo,
  input  logic [ADDR_W-1:0] grant_hi,
  input  logic [PID_W-1:0]  grant_pid,
  input  logic              grant_rd,
  input  logic              grant_wr,
  output logic              grant_ack,
  output logic [IDX_W-1:0]  grant_slot,
  output logic              grant_evict,
  input  logic              revoke_valid,
  input  logic [IDX_W-1:0]  revoke_slot,
  input  logic              rw_valid,
  input  logic              rw_copy,
  input  logic [REG_W-1:0]  rw_dst,
  input  logic [REG_W-1:0]  rw_src,
  input  logic              acc_valid,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [PID_W-1:0]  acc_pid,
  input  logic              acc_write,
  output logic              acc_done,
  output logic              acc_checked,
  output logic              acc_fault
);
  logic [IDX_W-1:0]  ins_slot;
  logic              ins_evict;
  logic              tag_v;
  logic [IDX_W-1:0]  tag_idx;
  logic              e_vld, e_rd, e_wr;
  logic [ADDR_W-1:0] e_lo, e_hi;
  logic [PID_W-1:0]  e_pid;
  spb_pkg::rw_op_e   rw_op;

  assign rw_op = rw_copy ? spb_pkg::RW_COPY : spb_pkg::RW_NULL;

  spb_entry_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PID_W(PID_W), .IDX_W(IDX_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_en    (grant_valid),
    .ins_lo    (grant_lo),
    .ins_hi    (grant_hi),
    .ins_pid   (grant_pid),
    .ins_rd    (grant_rd),
    .ins_wr    (grant_wr),
    .ins_slot  (ins_slot),
    .ins_evict (ins_evict),
    .rev_en    (revoke_valid),
    .rev_idx   (revoke_slot),
    .look_idx  (tag_idx),
    .look_vld  (e_vld),
    .look_lo   (e_lo),
    .look_hi   (e_hi),
    .look_pid  (e_pid),
    .look_rd   (e_rd),
    .look_wr   (e_wr)
  );

  spb_reg_tags #(.REGS(REGS), .IDX_W(IDX_W), .REG_W(REG_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rw_valid),
    .wr_op   (rw_op),
    .wr_dst  (rw_dst),
    .wr_src  (rw_src),
    .tag_en  (grant_valid),
    .tag_reg (grant_reg),
    .tag_idx (ins_slot),
    .rd_reg  (acc_reg),
    .rd_v    (tag_v),
    .rd_idx  (tag_idx)
  );

  // Single-cycle check against the tagged slot.
  logic in_range, pid_ok, perm_ok, pass;
  assign in_range = (acc_addr >= e_lo) && (acc_addr < e_hi);
  assign pid_ok   = (acc_pid == e_pid);
  assign perm_ok  = acc_write ? e_wr : e_rd;
  assign pass     = e_vld && in_range && pid_ok && perm_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_ack   <= 1'b0;
      grant_slot  <= '0;
      grant_evict <= 1'b0;
      acc_done    <= 1'b0;
      acc_checked <= 1'b0;
      acc_fault   <= 1'b0;
    end else begin
      grant_ack   <= grant_valid;
      grant_evict <= grant_valid && ins_evict;
      if (grant_valid) grant_slot <= ins_slot;
      acc_done    <= acc_valid;
      acc_checked <= acc_valid && tag_v;
      acc_fault   <= acc_valid && tag_v && !pass;
    end
  end

  // R7: every access gets its result exactly one cycle later
  p_done_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> acc_done);

  // R10: untagged accesses never fault
  p_untagged_no_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !tag_v) |=> !acc_fault);
endmodule

// File: tb/tb_spb_guard.sv
module tb_spb_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 64;

  logic        clk = 0, rst_n = 0;
  logic        grant_valid = 0, grant_rd = 0, grant_wr = 0;
  logic [3:0]  grant_reg = 0;
  logic [31:0] grant_lo = 0, grant_hi = 0;
  logic [7:0]  grant_pid = 0;
  logic        grant_ack, grant_evict;
  logic [5:0]  grant_slot;
  logic        revoke_valid = 0;
  logic [5:0]  revoke_slot = 0;
  logic        rw_valid = 0, rw_copy = 0;
  logic [3:0]  rw_dst = 0, rw_src = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [3:0]  acc_reg = 0;
  logic [31:0] acc_addr = 0;
  logic [7:0]  acc_pid = 0;
  logic        acc_done, acc_checked, acc_fault;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spb_guard dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_grant(input logic [3:0] r, input logic [31:0] lo, hi,
                          input logic [7:0] pid, input logic rd, wr);
    @(negedge clk);
    grant_valid = 1; grant_reg = r; grant_lo = lo; grant_hi = hi;
    grant_pid = pid; grant_rd = rd; grant_wr = wr;
    @(posedge clk); #1;
    grant_valid = 0;
  endtask

  task automatic do_access(string req, input logic [3:0] r, input logic [31:0] a,
                           input logic [7:0] pid, input logic wr,
                           input logic exp_chk, exp_flt);
    @(negedge clk);
    acc_valid = 1; acc_reg = r; acc_addr = a; acc_pid = pid; acc_write = wr;
    @(posedge clk); #1;
    acc_valid = 0;
    check({req, " done"}, acc_done, 1);
    check({req, " checked"}, acc_checked, exp_chk);
    check({req, " fault"}, acc_fault, exp_flt);
  endtask

  task automatic do_rw(input logic cp, input logic [3:0] d, s);
    @(negedge clk);
    rw_valid = 1; rw_copy = cp; rw_dst = d; rw_src = s;
    @(posedge clk); #1;
    rw_valid = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 ack", grant_ack, 0);
    check("R1 evict", grant_evict, 0);
    check("R1 done", acc_done, 0);
    check("R1 fault", acc_fault, 0);
    @(negedge clk); rst_n = 1;
    do_access("R1 no tag", 4'd0, 32'h0, 8'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_grant_and_check();
    do_grant(4'd1, 32'h1000, 32'h1040, 8'd3, 1'b1, 1'b0);
    check("R2 ack", grant_ack, 1);
    check("R2 slot0", grant_slot, 0);
    check("R2 evict", grant_evict, 0);
    do_grant(4'd2, 32'h2000, 32'h2100, 8'd3, 1'b1, 1'b1);
    check("R2 slot1", grant_slot, 1);
    do_access("R4 R7 low edge", 4'd1, 32'h1000, 8'd3, 1'b0, 1'b1, 1'b0);
    do_access("R7 top-1", 4'd1, 32'h103F, 8'd3, 1'b0, 1'b1, 1'b0);
    do_access("R8 at high", 4'd1, 32'h1040, 8'd3, 1'b0, 1'b1, 1'b1);
    do_access("R8 below low", 4'd1, 32'h0FFF, 8'd3, 1'b0, 1'b1, 1'b1);
    do_access("R9 pid", 4'd1, 32'h1010, 8'd4, 1'b0, 1'b1, 1'b1);
    do_access("R9 ro write", 4'd1, 32'h1010, 8'd3, 1'b1, 1'b1, 1'b1);
    do_access("R7 write ok", 4'd2, 32'h2080, 8'd3, 1'b1, 1'b1, 1'b0);
    do_access("R10 untagged", 4'd5, 32'hDEAD0000, 8'd9, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_copy_null();
    do_rw(1'b1, 4'd6, 4'd1);
    do_access("R5 copy pass", 4'd6, 32'h1010, 8'd3, 1'b0, 1'b1, 1'b0);
    do_access("R5 copy fault", 4'd6, 32'h1040, 8'd3, 1'b0, 1'b1, 1'b1);
    do_rw(1'b0, 4'd6, 4'd0);
    do_access("R6 null", 4'd6, 32'h5000, 8'd7, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_revoke();
    @(negedge clk);
    revoke_valid = 1; revoke_slot = 6'd0;
    @(posedge clk); #1;
    revoke_valid = 0;
    do_access("R11 revoked", 4'd1, 32'h1000, 8'd3, 1'b0, 1'b1, 1'b1);
    do_grant(4'd7, 32'h3000, 32'h3010, 8'd5, 1'b1, 1'b1);
    check("R11 reuse slot", grant_slot, 0);
    check("R11 no evict", grant_evict, 0);
    do_access("R11 new grant", 4'd7, 32'h3004, 8'd5, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_collision();
    @(negedge clk);
    grant_valid = 1; grant_reg = 4'd8; grant_lo = 32'h4000; grant_hi = 32'h4100;
    grant_pid = 8'd2; grant_rd = 1; grant_wr = 0;
    rw_valid = 1; rw_copy = 0; rw_dst = 4'd8; rw_src = 4'd0;
    @(posedge clk); #1;
    grant_valid = 0; rw_valid = 0;
    check("R12 slot", grant_slot, 2);
    do_access("R12 tag wins", 4'd8, 32'h4050, 8'd2, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_fill_evict();
    for (int i = 3; i < ENTRIES; i++) begin
      do_grant(4'd9, 32'h100 * i, 32'h100 * i + 32'h10, 8'd1, 1'b1, 1'b0);
      check("R2 fill slot", grant_slot, i);
      check("R2 fill evict", grant_evict, 0);
    end
    do_grant(4'd10, 32'h9000, 32'h9010, 8'd9, 1'b1, 1'b1);
    check("R3 evict", grant_evict, 1);
    check("R3 ack", grant_ack, 1);
    do_access("R3 victim pass", 4'd10, 32'h9008, 8'd9, 1'b1, 1'b1, 1'b0);
    do_access("R3 victim high", 4'd10, 32'h9010, 8'd9, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_grant_and_check();
    t_copy_null();
    t_revoke();
    t_collision();
    t_fill_evict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule